// File: doc/BRIEF.md
# Gated-Timebase BCD Interval Counter

This block measures the time between a start strobe and a stop strobe. It counts timebase ticks while a timing gate is open. The ticks are clock enables derived from the system clock at one of three selectable rates in the ratio 100 : 50 : 20, and the fastest rate is one tick per clock. The count is held in cascaded decimal decades, so a decimal address can be taken straight from the digits.

The control logic around the block holds a busy input high while an earlier measurement is still being handled. A start strobe that arrives while busy is high does nothing. If no stop arrives, the gate closes by itself once the count reaches the end of the range, which is just under 400 ticks at every rate. In that case an overflow flag is raised and held. A scaler-reset strobe returns the block to idle between measurements.

Top module: `bcd_interval_timer`

## Requirements
- R1: After reset, gate_o is 0, ovf_o is 0 and every digit of bcd_o is 0.
- R2: rate_sel selects the tick period in clocks: 0 gives 1, 1 gives 2, 2 gives 5, and 3 behaves as 0. The tick divider restarts when the gate opens, so N clocks after the opening edge the count is floor(N / period). Between ticks the count does not change.
- R3: A start strobe opens the gate on the next edge only when the gate is closed, busy_i is low and ovf_o is low. The same edge clears all digits to 0. While busy_i is high a start strobe leaves gate_o and bcd_o unchanged.
- R4: A stop strobe while the gate is open closes it on the next edge. A tick that falls on that same edge is not counted, and the count then holds its value.
- R5: bcd_o carries one decimal digit per 4-bit field: bits 3:0 are units, 7:4 tens and 11:8 hundreds. Every field always lies in 0..9.
- R6: If no stop arrives, the tick that brings the count to 399 also closes the gate and sets ovf_o. The count then stays at 399.
- R7: ovf_o stays set until clr_i. While ovf_o is set, a start strobe is ignored.
- R8: clr_i closes the gate, clears ovf_o and sets every digit to 0 on the next edge. It takes priority over start and stop.
- R9: A digit that steps from 9 wraps to 0 and carries into the next digit on the same edge, so 099 steps directly to 100.
- R10: A start strobe while the gate is already open has no effect, and counting continues without a restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rate_sel | input | 2 | Tick-rate select (0 full, 1 half, 2 one fifth, 3 full) |
| start_i | input | 1 | Start strobe |
| stop_i | input | 1 | Stop strobe |
| busy_i | input | 1 | High while the control logic is handling an earlier event |
| clr_i | input | 1 | Scaler-reset strobe |
| bcd_o | output | 12 | Three-decade decimal count, units in the low field |
| gate_o | output | 1 | Timing gate open |
| ovf_o | output | 1 | Range expired before a stop arrived |

## Verification
The assertions assume that all inputs are synchronous to clk and are either held steady or changed between edges. They also assume that rate_sel does not change while the gate is open. The stimulus drives every input on the falling edge and changes rate_sel only after a scaler reset. Start, stop and clear are issued as single-cycle pulses, apart from the deliberate start-during-open, start-during-busy and start-during-overflow cases.

// File: rtl/bit_pkg.sv
package bit_pkg;

    typedef enum logic [1:0] {
        RATE_FULL  = 2'd0,
        RATE_HALF  = 2'd1,
        RATE_FIFTH = 2'd2,
        RATE_ALT   = 2'd3
    } rate_e;

    typedef struct packed {
        logic gate;
        logic ovf;
    } ctl_t;

    // Decimal encoding of a value, eight decades, units in the low nibble.
    function automatic logic [31:0] bin2bcd(input int unsigned v);
        logic [31:0] r;
        int unsigned t;
        r = '0;
        t = v;
        for (int i = 0; i < 8; i++) begin
            r[4*i +: 4] = 4'(t % 10);
            t = t / 10;
        end
        return r;
    endfunction

endpackage

// File: rtl/bit_tick_gen.sv
module bit_tick_gen #(
    parameter int DIV_FULL = 1,
    parameter int DIV_HALF = 2,
    parameter int DIV_SLOW = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] rate_sel,
    input  logic       restart,
    input  logic       run,
    output logic       tick
);
    import bit_pkg::*;

    localparam int MAXD_A = (DIV_FULL > DIV_HALF) ? DIV_FULL : DIV_HALF;
    localparam int MAXD   = (MAXD_A > DIV_SLOW) ? MAXD_A : DIV_SLOW;
    localparam int PW     = (MAXD > 1) ? $clog2(MAXD) : 1;
    localparam logic [PW-1:0] LIM_FULL = PW'(DIV_FULL - 1);
    localparam logic [PW-1:0] LIM_HALF = PW'(DIV_HALF - 1);
    localparam logic [PW-1:0] LIM_SLOW = PW'(DIV_SLOW - 1);

    logic [PW-1:0] pre_d, pre_q;
    logic [PW-1:0] lim;
    logic          last;

    always_comb begin
        case (rate_e'(rate_sel))
            RATE_HALF:  lim = LIM_HALF;
            RATE_FIFTH: lim = LIM_SLOW;
            default:    lim = LIM_FULL;
        endcase
        last  = (pre_q == lim);
        tick  = run && last;
        pre_d = pre_q;
        if (restart) begin
            pre_d = '0;
        end else if (run) begin
            pre_d = last ? '0 : pre_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_d;
        end
    end

endmodule

// File: rtl/bit_bcd_decade.sv
module bit_bcd_decade (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       zero_i,
    input  logic       inc_i,
    output logic [3:0] digit_o,
    output logic       carry_o
);
    logic [3:0] dig_d, dig_q;
    logic       at_nine;

    always_comb begin
        at_nine = (dig_q == 4'd9);
        carry_o = inc_i && at_nine;
        dig_d   = dig_q;
        if (zero_i) begin
            dig_d = 4'd0;
        end else if (inc_i) begin
            dig_d = at_nine ? 4'd0 : dig_q + 4'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dig_q <= 4'd0;
        end else begin
            dig_q <= dig_d;
        end
    end

    assign digit_o = dig_q;

endmodule

// File: rtl/bcd_interval_timer.sv
module bcd_interval_timer #(
    parameter int NDIG     = 3,
    parameter int RANGE    = 399,
    parameter int DIV_FULL = 1,
    parameter int DIV_HALF = 2,
    parameter int DIV_SLOW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        rate_sel,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              busy_i,
    input  logic              clr_i,
    output logic [4*NDIG-1:0] bcd_o,
    output logic              gate_o,
    output logic              ovf_o
);
    import bit_pkg::*;

    localparam int              CW        = 4 * NDIG;
    localparam logic [31:0]     LAST_FULL = bin2bcd(RANGE - 1);
    localparam logic [CW-1:0]   LAST_BCD  = LAST_FULL[CW-1:0];

    ctl_t            ctl_d, ctl_q;
    logic            tick;
    logic            open_ok;
    logic            step;
    logic            expire;
    logic            zero;
    logic [NDIG:0]   cy;
    logic [CW-1:0]   digits;

    always_comb begin
        open_ok = !ctl_q.gate && !ctl_q.ovf && start_i && !busy_i && !clr_i;
        step    = tick && !stop_i && !clr_i;
        expire  = step && (digits == LAST_BCD);
        zero    = clr_i || open_ok;
        cy[0]   = step;

        ctl_d = ctl_q;
        if (clr_i) begin
            ctl_d.gate = 1'b0;
            ctl_d.ovf  = 1'b0;
        end else if (!ctl_q.gate) begin
            if (open_ok) begin
                ctl_d.gate = 1'b1;
            end
        end else if (stop_i) begin
            ctl_d.gate = 1'b0;
        end else if (expire) begin
            ctl_d.gate = 1'b0;
            ctl_d.ovf  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    bit_tick_gen #(
        .DIV_FULL (DIV_FULL),
        .DIV_HALF (DIV_HALF),
        .DIV_SLOW (DIV_SLOW)
    ) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .rate_sel (rate_sel),
        .restart  (zero),
        .run      (ctl_q.gate),
        .tick     (tick)
    );

    for (genvar g = 0; g < NDIG; g++) begin : g_dec
        bit_bcd_decade u_dec (
            .clk     (clk),
            .rst_n   (rst_n),
            .zero_i  (zero),
            .inc_i   (cy[g]),
            .digit_o (digits[4*g +: 4]),
            .carry_o (cy[g+1])
        );
    end

    assign bcd_o  = digits;
    assign gate_o = ctl_q.gate;
    assign ovf_o  = ctl_q.ovf;

endmodule

// File: rtl/bit_timer_chk.sv
module bit_timer_chk #(
    parameter int NDIG = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              stop_i,
    input logic              busy_i,
    input logic              clr_i,
    input logic [4*NDIG-1:0] bcd_o,
    input logic              gate_o,
    input logic              ovf_o
);
    // R8
    clear_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (!gate_o && !ovf_o && bcd_o == '0));

    // R3
    busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_o && busy_i && !clr_i) |=> (!gate_o && $stable(bcd_o)));

    // R4
    hold_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_o && !clr_i && !(start_i && !busy_i)) |=> $stable(bcd_o));

    // R4
    stop_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_o && stop_i && !clr_i) |=> (!gate_o && $stable(bcd_o)));

    // R7
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !clr_i) |=> ovf_o);

    // R6
    ovf_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_o) |-> (!gate_o && $past(gate_o)));

    // R10
    stay_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_o && !stop_i && !clr_i && !ovf_o && start_i) |=> (gate_o || ovf_o));

    // R5
    for (genvar g = 0; g < NDIG; g++) begin : g_dig
        digit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            bcd_o[4*g +: 4] <= 4'd9);
    end

endmodule

bind bcd_interval_timer bit_timer_chk #(.NDIG(NDIG)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .stop_i  (stop_i),
    .busy_i  (busy_i),
    .clr_i   (clr_i),
    .bcd_o   (bcd_o),
    .gate_o  (gate_o),
    .ovf_o   (ovf_o)
);

// File: tb/bcd_interval_timer_tb.sv
module bcd_interval_timer_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  rate_sel = 2'd0;
    logic        start_i = 1'b0;
    logic        stop_i = 1'b0;
    logic        busy_i = 1'b0;
    logic        clr_i = 1'b0;
    logic [11:0] bcd_o;
    logic        gate_o;
    logic        ovf_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    bcd_interval_timer u_dut (
        .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .start_i(start_i),
        .stop_i(stop_i), .busy_i(busy_i), .clr_i(clr_i),
        .bcd_o(bcd_o), .gate_o(gate_o), .ovf_o(ovf_o)
    );

    // {rate[15:14], open clocks[13:0]}
    localparam logic [15:0] VEC [12] = '{
        {2'd0, 14'd0},   {2'd0, 14'd7},   {2'd0, 14'd123}, {2'd0, 14'd100},
        {2'd1, 14'd9},   {2'd1, 14'd41},  {2'd2, 14'd13},  {2'd2, 14'd250},
        {2'd3, 14'd15},  {2'd0, 14'd99},  {2'd1, 14'd200}, {2'd2, 14'd4}
    };

    function automatic logic [11:0] dec3(input int v);
        return {4'(v / 100), 4'((v / 10) % 10), 4'(v % 10)};
    endfunction

    function automatic int period(input logic [1:0] r);
        return (r == 2'd1) ? 2 : (r == 2'd2) ? 5 : 1;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_clr();
        clr_i = 1'b1; cyc(1); clr_i = 1'b0;
    endtask

    task automatic pulse_start();
        start_i = 1'b1; cyc(1); start_i = 1'b0;
    endtask

    task automatic pulse_stop();
        stop_i = 1'b1; cyc(1); stop_i = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        cyc(2);
        // R1 reset state
        chk("R1 gate", gate_o, 0);
        chk("R1 ovf", ovf_o, 0);
        chk("R1 count", bcd_o, 0);
        rst_n = 1'b1;
        cyc(1);

        // table: R2 rates, R4 stop hold, R5 digit fields, R9 carry
        foreach (VEC[i]) begin
            logic [1:0] r;
            int n, e;
            r = VEC[i][15:14];
            n = int'(VEC[i][13:0]);
            e = n / period(r);
            rate_sel = r;
            pulse_clr();
            pulse_start();
            cyc(n);
            pulse_stop();
            chk("R2 R4 R5 R9 count", bcd_o, dec3(e));
            chk("R4 gate closed", gate_o, 0);
            cyc(3);
            chk("R4 count holds", bcd_o, dec3(e));
        end

        // R2: slow rate never counts on the raw clock
        rate_sel = 2'd2;
        pulse_clr();
        pulse_start();
        cyc(4);
        chk("R2 before tick", bcd_o, 0);
        cyc(1);
        chk("R2 first tick", bcd_o, 1);
        cyc(4);
        chk("R2 between ticks", bcd_o, 1);
        pulse_stop();

        // R9 carry 099 -> 100 on one edge
        rate_sel = 2'd0;
        pulse_clr();
        pulse_start();
        cyc(99);
        chk("R9 at 099", bcd_o, 12'h099);
        cyc(1);
        chk("R9 at 100", bcd_o, 12'h100);
        pulse_stop();

        // R3 busy blocks start; start clears digits
        chk("R3 held count", bcd_o, 12'h100);
        busy_i = 1'b1;
        pulse_start();
        cyc(3);
        chk("R3 busy gate", gate_o, 0);
        chk("R3 busy count", bcd_o, 12'h100);
        busy_i = 1'b0;
        pulse_start();
        chk("R3 start opens", gate_o, 1);
        chk("R3 start clears", bcd_o, 0);
        pulse_stop();

        // R10 start while open ignored
        pulse_clr();
        pulse_start();
        cyc(5);
        pulse_start();
        cyc(4);
        pulse_stop();
        chk("R10 no restart", bcd_o, dec3(10));

        // R6 range expiry at full rate
        pulse_clr();
        pulse_start();
        cyc(398);
        chk("R6 open at 398", gate_o, 1);
        chk("R6 count 398", bcd_o, 12'h398);
        cyc(1);
        chk("R6 closed", gate_o, 0);
        chk("R6 ovf", ovf_o, 1);
        cyc(10);
        chk("R6 holds 399", bcd_o, 12'h399);

        // R7 sticky overflow, start ignored
        pulse_start();
        cyc(3);
        chk("R7 start ignored gate", gate_o, 0);
        chk("R7 ovf sticky", ovf_o, 1);
        chk("R7 count kept", bcd_o, 12'h399);

        // R8 clear has priority over start
        start_i = 1'b1; clr_i = 1'b1; cyc(1); start_i = 1'b0; clr_i = 1'b0;
        chk("R8 gate", gate_o, 0);
        chk("R8 ovf", ovf_o, 0);
        chk("R8 count", bcd_o, 0);

        // R8 clear while open
        pulse_start();
        cyc(20);
        pulse_clr();
        chk("R8 open clear gate", gate_o, 0);
        chk("R8 open clear count", bcd_o, 0);

        // R6 expiry at half rate
        rate_sel = 2'd1;
        pulse_clr();
        pulse_start();
        cyc(805);
        chk("R6 half ovf", ovf_o, 1);
        chk("R6 half count", bcd_o, 12'h399);

        // R4 stop on a tick edge is not counted
        rate_sel = 2'd2;
        pulse_clr();
        pulse_start();
        cyc(9);
        pulse_stop();
        chk("R4 tick at stop dropped", bcd_o, 1);

        done = 1'b1;
        finish_run();
    end

endmodule